// File: doc/BRIEF.md
# Sampling Array Readout Sequencer

This block empties a halted switched-capacitor sampling array into waveform memory. On a start pulse it takes a snapshot of its configuration: the channel span (first and last channel number), the cascade code that sets how many cells each channel owns, the origin mode, and the cell position at which sampling froze. It then steps through every cell of every channel in the span, one cell per clock. In each of those cycles it asserts the array's shift-register clock enable and, in the same cycle so the phase between them is fixed, the ADC sample enable.

The ADC returns each 14-bit word a fixed number of cycles after its sample enable. An internal delay line carries the matching memory address for that many stages, so each word is written to the address of the cell it came from. A memory region is laid out for each channel in channel order. Within a region the address is the physical cell index. In "from stop" mode the walk begins at the frozen cell and wraps around the ring. An indicator pulses once as each readout begins, and a one-cycle done flag follows the final write.

Top module: `sca_readout_seq`

## Requirements
- R1: After reset, the shift enable, the sample enable, the memory write enable, the indicator and the done flag are all low.
- R2: A start pulse with a valid span raises the indicator for exactly one cycle. It is followed in the next cycle by a run of consecutive strobe cycles, one for each cell of each channel in the span. Shift enable and sample enable are high together in each strobe cycle and low together outside them.
- R3: The cascade code sets the depth per channel as a fraction of CELLS = 2^CELL_W (64 by default). Code 0x01 gives CELLS, 0x11 gives CELLS/2, 0x33 gives CELLS/4, and 0xFF or any other code gives CELLS/8.
- R4: With the origin mode input at 0, each channel's cells are read in the order 0, 1, ..., depth-1.
- R5: With the origin mode input at 1, each channel starts at the stop cell modulo the depth and wraps through the ring, covering every cell exactly once.
- R6: The memory address of a sample is (channel - first) * depth + physical cell index.
- R7: Each memory write happens exactly ADC_LAT cycles (3 by default) after its strobe and carries the ADC input word of that cycle.
- R8: The done flag is high for exactly one cycle, the cycle after the last write. No strobe or write occurs in that cycle.
- R9: A start with first > last or last > 9 produces no indicator, no strobes and no writes. Done rises for one cycle in the cycle after the start.
- R10: Start pulses and configuration changes while a readout is in progress have no effect on that readout.
- R11: During each strobe the channel output holds the channel number being read: first + channel offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start pulse, sampled when idle |
| from_stop_i | input | 1 | Origin mode: 0 = cell 0, 1 = stop cell |
| first_ch_i | input | 4 | First channel of the span |
| last_ch_i | input | 4 | Last channel of the span |
| cascade_i | input | 8 | Cascade code selecting depth per channel |
| stop_cell_i | input | CELL_W | Cell position where sampling froze |
| sr_clk_en_o | output | 1 | Shift-register clock enable toward the array |
| adc_smp_o | output | 1 | ADC sample enable, phase-locked to the shift enable |
| chan_o | output | 4 | Channel being read |
| adc_data_i | input | 14 | ADC output word |
| ram_we_o | output | 1 | Memory write enable |
| ram_addr_o | output | 4+CELL_W | Memory write address |
| ram_data_o | output | 14 | Memory write data |
| led_o | output | 1 | One-cycle pulse at readout start |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
The bench aims at the wrap of the ring when the stop cell lies near the top of a channel, and at each cascade code including an unlisted one. A design that masked with the wrong depth would produce duplicate or out-of-region addresses. It also checks the exact spacing between strobe and write: a delay line one stage short or long would pair every address with the word of a neighbouring cell. Reversed and out-of-range spans, and start pulses during a busy readout, are used to expose a sequencer that restarts, or that strobes channels beyond nine.

// File: rtl/sca_rdo_pkg.sv
package sca_rdo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SHIFT,
        ST_DRAIN,
        ST_FINISH
    } rdo_state_e;

    // Right shift of the full array depth that a cascade code implies.
    function automatic logic [1:0] cascade_shift(input logic [7:0] code);
        logic [1:0] sh;
        unique case (code)
            8'h01:   sh = 2'd0;
            8'h11:   sh = 2'd1;
            8'h33:   sh = 2'd2;
            default: sh = 2'd3;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/sca_rdo_cellwalk.sv
module sca_rdo_cellwalk #(
    parameter int CELL_W = 6,
    parameter int CH_W   = 4,
    localparam int SH_W   = $clog2(CELL_W + 1),
    localparam int ADDR_W = CH_W + CELL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [SH_W-1:0]   dlog_i,
    input  logic [CELL_W-1:0] start_i,
    input  logic [CH_W-1:0]   first_i,
    input  logic [CH_W-1:0]   last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              final_o
);

    logic [CELL_W-1:0] k_q;
    logic [CH_W-1:0]   idx_q;
    logic [CH_W-1:0]   chan_q;
    logic [CELL_W:0]   depth_w;
    logic [CELL_W-1:0] mask;
    logic [CELL_W-1:0] phys;
    logic              cell_end;

    always_comb begin
        depth_w  = (CELL_W + 1)'(1) << dlog_i;
        mask     = CELL_W'(depth_w - 1'b1);
        phys     = (start_i + k_q) & mask;
        cell_end = (k_q == mask);
        final_o  = cell_end && (chan_q == last_i);
        addr_o   = (ADDR_W'(idx_q) << dlog_i) | ADDR_W'(phys);
        chan_o   = chan_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q    <= '0;
            idx_q  <= '0;
            chan_q <= '0;
        end else if (load_i) begin
            k_q    <= '0;
            idx_q  <= '0;
            chan_q <= first_i;
        end else if (step_i) begin
            if (cell_end) begin
                k_q    <= '0;
                idx_q  <= idx_q + 1'b1;
                chan_q <= chan_q + 1'b1;
            end else begin
                k_q    <= k_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sca_rdo_align.sv
module sca_rdo_align #(
    parameter int LAT = 3,
    parameter int W   = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] tag_i,
    output logic         vld_o,
    output logic [W-1:0] tag_o
);

    logic         v_q [LAT];
    logic [W-1:0] t_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                v_q[i] <= 1'b0;
                t_q[i] <= '0;
            end
        end else begin
            v_q[0] <= vld_i;
            t_q[0] <= tag_i;
            for (int i = 1; i < LAT; i++) begin
                v_q[i] <= v_q[i-1];
                t_q[i] <= t_q[i-1];
            end
        end
    end

    assign vld_o = v_q[LAT-1];
    assign tag_o = t_q[LAT-1];

endmodule

// File: rtl/sca_readout_seq.sv
module sca_readout_seq
    import sca_rdo_pkg::*;
#(
    parameter int CELL_W  = 6,
    parameter int ADC_W   = 14,
    parameter int ADC_LAT = 3,
    parameter int MAX_CH  = 9,
    localparam int CH_W   = 4,
    localparam int SH_W   = $clog2(CELL_W + 1),
    localparam int ADDR_W = CH_W + CELL_W,
    localparam int DW     = $clog2(ADC_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              from_stop_i,
    input  logic [CH_W-1:0]   first_ch_i,
    input  logic [CH_W-1:0]   last_ch_i,
    input  logic [7:0]        cascade_i,
    input  logic [CELL_W-1:0] stop_cell_i,
    output logic              sr_clk_en_o,
    output logic              adc_smp_o,
    output logic [CH_W-1:0]   chan_o,
    input  logic [ADC_W-1:0]  adc_data_i,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [ADC_W-1:0]  ram_data_o,
    output logic              led_o,
    output logic              done_o
);

    rdo_state_e        state_q, state_d;
    logic [CH_W-1:0]   first_q, last_q;
    logic [SH_W-1:0]   dlog_q;
    logic [CELL_W-1:0] start_q;
    logic [DW-1:0]     drain_q;
    logic              range_ok;
    logic              walk_load, walk_step, walk_final;
    logic [ADDR_W-1:0] walk_addr;

    assign range_ok = (first_ch_i <= last_ch_i) && (last_ch_i <= CH_W'(MAX_CH));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_i) state_d = range_ok ? ST_LAUNCH : ST_FINISH;
            ST_LAUNCH: state_d = ST_SHIFT;
            ST_SHIFT:  if (walk_final) state_d = ST_DRAIN;
            ST_DRAIN:  if (drain_q == DW'(ADC_LAT - 1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        led_o       = 1'b0;
        sr_clk_en_o = 1'b0;
        adc_smp_o   = 1'b0;
        done_o      = 1'b0;
        walk_load   = 1'b0;
        walk_step   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: begin led_o = 1'b1; walk_load = 1'b1; end
            ST_SHIFT:  begin sr_clk_en_o = 1'b1; adc_smp_o = 1'b1; walk_step = 1'b1; end
            ST_DRAIN:  ;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    // Configuration snapshot, taken only when a start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            dlog_q  <= SH_W'(CELL_W);
            start_q <= '0;
        end else if (state_q == ST_IDLE && go_i) begin
            first_q <= first_ch_i;
            last_q  <= last_ch_i;
            dlog_q  <= SH_W'(CELL_W) - SH_W'(cascade_shift(cascade_i));
            start_q <= from_stop_i ? stop_cell_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 drain_q <= '0;
        else if (state_q == ST_DRAIN) drain_q <= drain_q + 1'b1;
        else                        drain_q <= '0;
    end

    sca_rdo_cellwalk #(.CELL_W(CELL_W), .CH_W(CH_W)) walk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (walk_load),
        .step_i  (walk_step),
        .dlog_i  (dlog_q),
        .start_i (start_q),
        .first_i (first_q),
        .last_i  (last_q),
        .addr_o  (walk_addr),
        .chan_o  (chan_o),
        .final_o (walk_final)
    );

    sca_rdo_align #(.LAT(ADC_LAT), .W(ADDR_W)) align_i (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (adc_smp_o),
        .tag_i (walk_addr),
        .vld_o (ram_we_o),
        .tag_o (ram_addr_o)
    );

    assign ram_data_o = adc_data_i;

endmodule

// File: rtl/sca_readout_seq_chk.sv
module sca_readout_seq_chk #(
    parameter int ADC_LAT = 3,
    parameter int MAX_CH  = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       led_o,
    input logic       done_o,
    input logic       adc_smp_o,
    input logic       ram_we_o,
    input logic [3:0] chan_o
);

    AST_LED_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) led_o |=> !led_o); // R2
    AST_STROBE_AFTER_LED: assert property (@(posedge clk) disable iff (!rst_n) $rose(adc_smp_o) |-> $past(led_o)); // R2
    AST_WRITE_LATENCY:  assert property (@(posedge clk) disable iff (!rst_n) ram_we_o |-> $past(adc_smp_o, ADC_LAT)); // R7
    AST_DONE_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
    AST_DONE_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (!adc_smp_o && !ram_we_o)); // R8
    AST_CHAN_IN_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) adc_smp_o |-> (chan_o <= 4'(MAX_CH))); // R11

endmodule

bind sca_readout_seq sca_readout_seq_chk #(.ADC_LAT(ADC_LAT), .MAX_CH(MAX_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .led_o     (led_o),
    .done_o    (done_o),
    .adc_smp_o (adc_smp_o),
    .ram_we_o  (ram_we_o),
    .chan_o    (chan_o)
);

// File: tb/sca_readout_seq_tb_top.sv
module sca_readout_seq_tb_top;

    localparam int CELL_W = 6;
    localparam int CELLS  = 1 << CELL_W;
    localparam int LAT    = 3;
    localparam int AW     = 4 + CELL_W;
    localparam int NMAX   = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go_i = 1'b0;
    logic              from_stop_i = 1'b0;
    logic [3:0]        first_ch_i = '0;
    logic [3:0]        last_ch_i = '0;
    logic [7:0]        cascade_i = 8'h01;
    logic [CELL_W-1:0] stop_cell_i = '0;
    logic              sr_clk_en_o, adc_smp_o, ram_we_o, led_o, done_o;
    logic [3:0]        chan_o;
    logic [13:0]       adc_data_i;
    logic [AW-1:0]     ram_addr_o;
    logic [13:0]       ram_data_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sca_readout_seq #(.CELL_W(CELL_W), .ADC_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .from_stop_i(from_stop_i),
        .first_ch_i(first_ch_i), .last_ch_i(last_ch_i), .cascade_i(cascade_i),
        .stop_cell_i(stop_cell_i), .sr_clk_en_o(sr_clk_en_o), .adc_smp_o(adc_smp_o),
        .chan_o(chan_o), .adc_data_i(adc_data_i), .ram_we_o(ram_we_o),
        .ram_addr_o(ram_addr_o), .ram_data_o(ram_data_o), .led_o(led_o), .done_o(done_o)
    );

    function automatic logic [13:0] adc_word(input int n);
        return 14'((n * 97 + 13) ^ 16'h1555);
    endfunction

    // ADC model: word of strobe n appears LAT cycles after that strobe
    logic [13:0] adc_pipe [LAT];
    int          adc_seq = 0;
    always @(posedge clk) begin
        if (adc_smp_o) begin
            adc_pipe[0] <= adc_word(adc_seq);
            adc_seq     <= adc_seq + 1;
        end else begin
            adc_pipe[0] <= '0;
        end
        for (int i = 1; i < LAT; i++) adc_pipe[i] <= adc_pipe[i-1];
    end
    assign adc_data_i = adc_pipe[LAT-1];

    // Output monitor, sampled mid-cycle
    int cyc = 0;
    int n_led = 0, n_s = 0, n_w = 0, n_d = 0, lock_bad = 0;
    int led_cyc [NMAX];
    int s_cyc   [NMAX];
    int s_chan  [NMAX];
    int w_cyc   [NMAX];
    int w_addr  [NMAX];
    int w_data  [NMAX];
    int d_cyc   [NMAX];
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sr_clk_en_o !== adc_smp_o) lock_bad <= lock_bad + 1;
        if (led_o) begin led_cyc[n_led] <= cyc; n_led <= n_led + 1; end
        if (adc_smp_o) begin
            s_cyc[n_s] <= cyc; s_chan[n_s] <= int'(chan_o); n_s <= n_s + 1;
        end
        if (ram_we_o) begin
            w_cyc[n_w] <= cyc; w_addr[n_w] <= int'(ram_addr_o);
            w_data[n_w] <= int'(ram_data_o); n_w <= n_w + 1;
        end
        if (done_o) begin d_cyc[n_d] <= cyc; n_d <= n_d + 1; end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 shift enable low", int'(sr_clk_en_o), 0);
        chk("R1 sample enable low", int'(adc_smp_o), 0);
        chk("R1 write enable low", int'(ram_we_o), 0);
        chk("R1 indicator low", int'(led_o), 0);
        chk("R1 done low", int'(done_o), 0);
    endtask

    task automatic run(input string name, input bit mode, input int first, input int last,
                       input logic [7:0] code, input int stop, input int depth, input bit poke);
        int bl, bs, bw, bd, nch, n, t, bad, start, gaps, chbad, abad, dbad, lbad;
        bl = n_led; bs = n_s; bw = n_w; bd = n_d;
        @(negedge clk);
        from_stop_i = mode; first_ch_i = 4'(first); last_ch_i = 4'(last);
        cascade_i = code; stop_cell_i = CELL_W'(stop); go_i = 1'b1;
        @(negedge clk) go_i = 1'b0;
        if (poke) begin
            // R10: new start and new configuration mid-run
            repeat (6) @(negedge clk);
            from_stop_i = ~mode; first_ch_i = 4'd0; last_ch_i = 4'd9;
            cascade_i = 8'h01; stop_cell_i = '0; go_i = 1'b1;
            @(negedge clk) go_i = 1'b0;
            repeat (4) @(negedge clk);
            go_i = 1'b1;
            @(negedge clk) go_i = 1'b0;
        end
        t = 0;
        while (n_d == bd && t < 3000) begin @(posedge clk); t++; end
        repeat (8) @(posedge clk);
        nch = last - first + 1;
        n = nch * depth;
        start = mode ? (stop % depth) : 0;
        chk({name, " R2 indicator pulses"}, n_led - bl, 1);
        chk({name, " R2 R3 strobe count"}, n_s - bs, n);
        chk({name, " R2 first strobe follows indicator"}, s_cyc[bs] - led_cyc[bl], 1);
        chk({name, " R2 shift and sample enables locked"}, lock_bad, 0);
        gaps = 0; chbad = 0; abad = 0; dbad = 0; lbad = 0;
        for (int j = 0; j < n; j++) begin
            int ci, k, ea;
            ci = j / depth; k = j % depth;
            ea = ci * depth + ((start + k) % depth);
            if (j > 0 && s_cyc[bs+j] != s_cyc[bs+j-1] + 1) gaps++;
            if (s_chan[bs+j] != first + ci) chbad++;
            if (w_addr[bw+j] != ea) begin
                if (abad == 0) $display("  %s first address mismatch at %0d: got %0d want %0d",
                                        name, j, w_addr[bw+j], ea);
                abad++;
            end
            if (w_data[bw+j] != int'(adc_word(bs + j))) dbad++;
            if (w_cyc[bw+j] - s_cyc[bs+j] != LAT) lbad++;
        end
        chk({name, " R2 strobes consecutive (gaps)"}, gaps, 0);
        chk({name, " R11 channel output mismatches"}, chbad, 0);
        chk({name, " R4 R5 R6 address mismatches"}, abad, 0);
        chk({name, " R7 write count"}, n_w - bw, n);
        chk({name, " R7 data mismatches"}, dbad, 0);
        chk({name, " R7 latency mismatches"}, lbad, 0);
        chk({name, " R8 done pulses"}, n_d - bd, 1);
        chk({name, " R8 done one cycle after last write"}, d_cyc[bd] - w_cyc[bw+n-1], 1);
        if (poke) chk({name, " R10 no extra strobes after done"}, n_s - bs, n);
    endtask

    task automatic run_invalid(input string name, input int first, input int last);
        int bl, bs, bw, bd;
        bl = n_led; bs = n_s; bw = n_w; bd = n_d;
        @(negedge clk);
        from_stop_i = 1'b0; first_ch_i = 4'(first); last_ch_i = 4'(last);
        cascade_i = 8'hFF; go_i = 1'b1;
        @(negedge clk) go_i = 1'b0;
        chk({name, " R9 done in cycle after start"}, int'(done_o), 1);
        repeat (12) @(posedge clk);
        #2;
        chk({name, " R9 no indicator"}, n_led - bl, 0);
        chk({name, " R9 no strobes"}, n_s - bs, 0);
        chk({name, " R9 no writes"}, n_w - bw, 0);
        chk({name, " R9 single done"}, n_d - bd, 1);
    endtask

    initial begin
        test_reset();
        run("cell0_full",      1'b0, 0, 0, 8'h01,  0, CELLS,     1'b0);   // R4 R3
        run("stop_half",       1'b1, 2, 3, 8'h11, 40, CELLS / 2, 1'b0);   // R5 R6 R3
        run("stop_quarter_all",1'b1, 0, 9, 8'h33, 63, CELLS / 4, 1'b0);   // R5 R3 R11
        run("cell0_eighth",    1'b0, 5, 7, 8'hFF, 17, CELLS / 8, 1'b0);   // R4 R3
        run("odd_code",        1'b1, 1, 2, 8'h5A, 29, CELLS / 8, 1'b0);   // R3 R5
        run("busy_start",      1'b1, 4, 5, 8'h11, 50, CELLS / 2, 1'b1);   // R10
        run_invalid("reversed", 6, 3);                                    // R9
        run_invalid("beyond9",  8, 12);                                   // R9
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule